// File: doc/BRIEF.md
# Single-Cycle AES-128 Round-Key Stepper

This block holds the working AES-128 round key as four 32-bit words and advances it to the next round key in a single clock cycle. It has no S-box of its own. It sends the last key word, rotated by one byte, out of the block. The surrounding core pushes that word through the S-boxes it already uses for the data path, during the cycle it reserves for key expansion. The substituted word comes back on `subWord`. The block then forms all four new words in that same cycle through a chained XOR network.

The cipher key enters one 32-bit word per cycle during a four-cycle load phase, first word first. For each round, the controller raises `stepReq` with the round number 1 to 10 and presents the substituted word. The block works out the round constant for that round. The current round key is always visible on `roundKey`.

Top module: `rkeyStep`

## Requirements
- R1: While `rstN` is low, all four key words are zero, so `roundKey` reads zero.
- R2: A cycle with `loadValid` high shifts the key words up by one: `roundKey[127:32]` takes the old `roundKey[95:0]` and `roundKey[31:0]` takes `loadWord`. After four loads, the first word loaded sits in `roundKey[127:96]` (word 0) and the last sits in `roundKey[31:0]` (word 3).
- R3: `sboxWord` always equals word 3 rotated left by one byte: `{roundKey[23:0], roundKey[31:24]}`.
- R4: A step with `loadValid` low, `stepReq` high and `roundIdx` in 1..10 replaces the key in the next cycle. The new word 0 is old word 0 XOR `subWord` XOR (round constant << 24). Each later new word k is old word k XOR new word k-1.
- R5: The round constant for round indices 1 to 10 is, in order, 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex). It is applied to the most significant byte of word 0 only.
- R6: A step request with `roundIdx` equal to 0 or in the range 11..15 is ignored, and the key is unchanged.
- R7: With neither `loadValid` nor `stepReq` high, the key holds its value.
- R8: When `loadValid` and `stepReq` are both high, the load is performed and the step is ignored.
- R9: Loading the cipher key 2b7e151628aed2a6abf7158809cf4f3c and stepping rounds 1 to 10 gives the standard expansion, ending in round key d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Shift `loadWord` into the key registers |
| loadWord | input | 32 | Cipher-key word being loaded |
| stepReq | input | 1 | Request to advance to the next round key |
| roundIdx | input | 4 | Round number of the requested step (valid 1..10) |
| subWord | input | 32 | `sboxWord` after byte-wise S-box substitution |
| sboxWord | output | 32 | Word 3 rotated one byte left, for the shared S-boxes |
| roundKey | output | 128 | Current round key, word 0 in the top bits |

## Verification
The assertions assume that `subWord` is already valid in the cycle that `stepReq` is high. They check only the XOR structure and do not check whether `subWord` really is the S-box image of `sboxWord`. The bench reads `sboxWord` after each edge and computes `subWord` with its own arithmetic S-box before it raises a step. For the ignored-step and priority cases, where the substitution does not matter, it drives arbitrary substituted words. Round indices are swept over all sixteen codes, so the valid and invalid ranges are both exercised.

// File: rtl/rkeyPkg.sv
package rkeyPkg;
  localparam int BYTE_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadEn;
    logic              stepEn;
    logic [BYTE_W-1:0] rcon;
  } keyCtrl_t;

  // Multiply by x in GF(2^8), reduction polynomial 0x11b
  function automatic logic [BYTE_W-1:0] xtime(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/rkeyCtrl.sv
module rkeyCtrl
  import rkeyPkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4
) (
  input  logic             loadValid,
  input  logic             stepReq,
  input  logic [IDX_W-1:0] roundIdx,
  output keyCtrl_t         ctrl
);
  logic             idxOk;
  logic [BYTE_W-1:0] rcon;

  assign idxOk = (roundIdx != '0) && (int'(roundIdx) <= NUM_ROUNDS);

  // Round constant: x^(idx-1), built by repeated doubling
  always_comb begin
    rcon = 8'h01;
    for (int i = 1; i < NUM_ROUNDS; i++) begin
      if (i < int'(roundIdx)) rcon = xtime(rcon);
    end
  end

  always_comb begin
    ctrl.loadEn = loadValid;
    ctrl.stepEn = stepReq && idxOk && !loadValid;  // load wins
    ctrl.rcon   = rcon;
  end
endmodule

// File: rtl/rkeyDatapath.sv
module rkeyDatapath
  import rkeyPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int KEY_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  keyCtrl_t          ctrl,
  input  logic [WORD_W-1:0] loadWord,
  input  logic [WORD_W-1:0] subWord,
  output logic [WORD_W-1:0] sboxWord,
  output logic [KEY_W-1:0]  roundKey
);
  logic [WORD_W-1:0] keyWord  [NUM_WORDS];
  logic [WORD_W-1:0] nextWord [NUM_WORDS];

  // Chained XOR network, each new word feeds the next
  always_comb begin
    logic [WORD_W-1:0] acc;
    acc = keyWord[0] ^ subWord ^ {ctrl.rcon, {(WORD_W-BYTE_W){1'b0}}};
    nextWord[0] = acc;
    for (int k = 1; k < NUM_WORDS; k++) begin
      acc = acc ^ keyWord[k];
      nextWord[k] = acc;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    logic [WORD_W-1:0] loadSrc;
    if (g == NUM_WORDS - 1) begin : gLast
      assign loadSrc = loadWord;
    end else begin : gMid
      assign loadSrc = keyWord[g+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            keyWord[g] <= '0;
      else if (ctrl.loadEn) keyWord[g] <= loadSrc;
      else if (ctrl.stepEn) keyWord[g] <= nextWord[g];
    end

    assign roundKey[(NUM_WORDS-g)*WORD_W-1 -: WORD_W] = keyWord[g];
  end

  // Rotate last word one byte left for the borrowed S-boxes
  assign sboxWord = {keyWord[NUM_WORDS-1][WORD_W-BYTE_W-1:0],
                     keyWord[NUM_WORDS-1][WORD_W-1 -: BYTE_W]};
endmodule

// File: rtl/rkeyStep.sv
module rkeyStep
  import rkeyPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 4,
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadValid,
  input  logic [WORD_W-1:0]           loadWord,
  input  logic                        stepReq,
  input  logic [IDX_W-1:0]            roundIdx,
  input  logic [WORD_W-1:0]           subWord,
  output logic [WORD_W-1:0]           sboxWord,
  output logic [WORD_W*NUM_WORDS-1:0] roundKey
);
  keyCtrl_t ctrl;

  rkeyCtrl #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .loadValid(loadValid),
    .stepReq  (stepReq),
    .roundIdx (roundIdx),
    .ctrl     (ctrl)
  );

  rkeyDatapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .loadWord(loadWord),
    .subWord (subWord),
    .sboxWord(sboxWord),
    .roundKey(roundKey)
  );
endmodule

// File: rtl/rkeyStepChk.sv
module rkeyStepChk (
  input logic         clk,
  input logic         rstN,
  input logic         loadValid,
  input logic [31:0]  loadWord,
  input logic         stepReq,
  input logic [3:0]   roundIdx,
  input logic [31:0]  subWord,
  input logic [31:0]  sboxWord,
  input logic [127:0] roundKey
);
  logic validStep;
  assign validStep = stepReq && !loadValid && (roundIdx != 4'd0) && (roundIdx <= 4'd10);

  // R2
  load_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> (roundKey[31:0] == $past(loadWord)) &&
                  (roundKey[127:32] == $past(roundKey[95:0])));

  // R4
  step_word0_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    validStep |=> roundKey[119:96] == $past(roundKey[119:96] ^ subWord[23:0]));

  // R4
  step_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    validStep |=> (roundKey[95:64] == ($past(roundKey[95:64]) ^ roundKey[127:96])) &&
                  (roundKey[31:0]  == ($past(roundKey[31:0])  ^ roundKey[63:32])));

  // R5
  first_rcon_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validStep && roundIdx == 4'd1) |=>
      roundKey[127:120] == ($past(roundKey[127:120] ^ subWord[31:24]) ^ 8'h01));

  // R6
  bad_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !loadValid && (roundIdx == 4'd0 || roundIdx > 4'd10)) |=> $stable(roundKey));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepReq && !loadValid) |=> $stable(roundKey));

  // R3
  always_comb begin
    if (rstN) begin
      rot_out_chk: assert (sboxWord == {roundKey[23:0], roundKey[31:24]});
    end
  end
endmodule

bind rkeyStep rkeyStepChk u_rkeyStepChk (
  .clk      (clk),
  .rstN     (rstN),
  .loadValid(loadValid),
  .loadWord (loadWord),
  .stepReq  (stepReq),
  .roundIdx (roundIdx),
  .subWord  (subWord),
  .sboxWord (sboxWord),
  .roundKey (roundKey)
);

// File: tb/rkeyStep_bench.sv
module rkeyStep_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadValid = 1'b0;
  logic [31:0]  loadWord = '0;
  logic         stepReq = 1'b0;
  logic [3:0]   roundIdx = '0;
  logic [31:0]  subWord = '0;
  logic [31:0]  sboxWord;
  logic [127:0] roundKey;

  int vectors = 0;
  int misses  = 0;

  always #2 clk = ~clk;  // 250 MHz

  rkeyStep u_rkeyStep (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadWord(loadWord),
    .stepReq(stepReq), .roundIdx(roundIdx), .subWord(subWord),
    .sboxWord(sboxWord), .roundKey(roundKey)
  );

  // ---- independent reference arithmetic ----
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h01;
    logic [7:0] r;
    for (int i = 0; i < 254; i++) inv = gmul(inv, a);  // a^254
    if (a == 8'h00) inv = 8'h00;
    r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
        {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return r;
  endfunction

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [7:0] rconOf(input int idx);
    logic [7:0] t [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                           8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    return t[idx-1];
  endfunction

  function automatic logic [127:0] expectNext(input logic [127:0] k, input logic [31:0] s,
                                              input int idx);
    logic [31:0] n0, n1, n2, n3;
    n0 = k[127:96] ^ s ^ {rconOf(idx), 24'h0};
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0]  ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadKey(input logic [127:0] k);
    for (int i = 0; i < 4; i++) begin
      loadValid = 1'b1;
      loadWord  = k[127-32*i -: 32];
      @(negedge clk);
    end
    loadValid = 1'b0;
  endtask

  // one step; sub from bench S-box of the current sboxWord
  task automatic stepOnce(input int idx, input logic [31:0] s);
    stepReq  = 1'b1;
    roundIdx = 4'(idx);
    subWord  = s;
    @(negedge clk);
    stepReq  = 1'b0;
  endtask

  task automatic fullExpand(input logic [127:0] key, input string tag);
    logic [127:0] model;
    logic [31:0]  s;
    loadKey(key);
    check("R2", roundKey, key);
    model = key;
    for (int r = 1; r <= 10; r++) begin
      check("R3", {96'h0, sboxWord}, {96'h0, model[23:0], model[31:24]});
      s = subW({model[23:0], model[31:24]});
      stepOnce(r, s);
      model = expectNext(model, s, r);
      check(tag, roundKey, model);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (2) @(negedge clk);
    check("R1", roundKey, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", roundKey, 128'h0);

    // R9 standard example; R4/R5 stepped for every round index
    fullExpand(128'h2b7e151628aed2a6abf7158809cf4f3c, "R4/R5");
    check("R9", roundKey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    // further keys, all rounds
    fullExpand(128'h000102030405060708090a0b0c0d0e0f, "R4");
    fullExpand(128'hffffffffffffffffffffffffffffffff, "R5");
    fullExpand(128'h0, "R4");
    for (int n = 0; n < 4; n++)
      fullExpand({$urandom, $urandom, $urandom, $urandom}, "R4");

    // R6: invalid round codes ignored
    for (int idx = 0; idx < 16; idx++) begin
      if (idx == 0 || idx > 10) begin
        held = roundKey;
        stepOnce(idx, $urandom);
        check("R6", roundKey, held);
      end
    end

    // R7: idle hold, with noise on data inputs
    held = roundKey;
    for (int c = 0; c < 5; c++) begin
      subWord = $urandom; loadWord = $urandom; roundIdx = 4'd3;
      @(negedge clk);
      check("R7", roundKey, held);
    end

    // R8: load beats step
    held = roundKey;
    loadValid = 1'b1; loadWord = 32'hcafef00d;
    stepReq = 1'b1; roundIdx = 4'd2; subWord = 32'h12345678;
    @(negedge clk);
    loadValid = 1'b0; stepReq = 1'b0;
    check("R8", roundKey, {held[95:0], 32'hcafef00d});

    // R1: reset clears a loaded key
    rstN = 1'b0;
    #1;
    check("R1", roundKey, 128'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule